// File: doc/BRIEF.md
# Dual-Clock Field Delay Memory

A byte-wide serial store that sits between two unrelated clock domains and behaves as a programmable delay line. A writer pushes bytes into a shared array at its own pace, and a reader pulls bytes out at its own pace. Each side walks its own address pointer, and that pointer returns to address zero only when the side's clear strobe is accepted. The delay between a byte going in and the same byte coming out is therefore set by when the two clear strobes happen, not by any full or empty bookkeeping.

Each side has two independent qualifiers. The advance qualifier decides whether the pointer moves at all. The access qualifier lets the pointer move without touching the data: on the write side this leaves the old byte in place, which allows selective overwrite of part of a stored field. On the read side it blanks the output slot, which allows bytes to be skipped. Everything on the write side acts one write-clock edge later than the same action on the read side. Because of this, the registered read output of one instance, with its valid flag used as the advance, can feed the write port of a following instance directly.

A clear strobe is only honoured after its input has been low for a minimum spacing of two edges in its own domain. A strobe that comes too early is dropped, and that domain's error flag is set and stays set.

Top module: `field_delay_mem`

## Requirements
- R1: After reset both pointers are at address 0, `rd_valid` and `rd_data` are 0 and both error flags are 0; writing and reading without any clear strobe starts at address 0.
- R2: An accepted clear strobe zeroes its pointer. In that cycle the side's advance and access inputs are ignored: no byte is written, no fetch takes place, and the read slot it produces has `rd_valid` 0.
- R3: With `wr_adv` high at a write-clock edge, `wr_data` is taken for the current write address and the pointer moves on by one. With `wr_adv` low, the pointer holds and nothing is stored.
- R4: With `wr_store` low in an advancing write cycle, the addressed location keeps its previous byte, but the write pointer still moves on.
- R5: With `rd_adv` high at a read-clock edge, the byte at the current read address is fetched and the pointer moves on. It appears on `rd_data` with `rd_valid` high after the following read-clock edge. With `rd_adv` low, the pointer holds and that slot has `rd_valid` 0.
- R6: With `rd_show` low in an advancing read cycle, the pointer still moves on, but that slot has `rd_valid` 0 and `rd_data` equal to 0.
- R7: A clear strobe sampled high is accepted only if the input was low at no fewer than two consecutive preceding edges of its own clock (reset counts as enough). A strobe with just one low edge before it is ignored, the cycle otherwise runs normally, and the domain's error flag goes to 1 and stays there until reset. A strobe held high acts only on its first edge.
- R8: Both pointers wrap from address DEPTH-1 to 0.
- R9: A byte taken at write edge k is stored into the array at write edge k+1, and a write clear strobe likewise takes effect one write edge late. With equal clock rates and the read edges 3 ns after the write edges, a reader cleared at the first read edge after the write clear strobe therefore gets the previous field.
- R10: A fetch returns whatever the array holds at the fetch edge. A reader that trails the writer by one or more full clocks gets the field being written. A reader that leads it gets the previous field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_zero | input | 1 | Write pointer clear strobe |
| wr_adv | input | 1 | Write pointer advance qualifier |
| wr_store | input | 1 | Write access qualifier (low keeps the old byte) |
| wr_data | input | DATA_W | Input byte |
| wr_gap_err | output | 1 | Sticky flag: write clear strobe broke the spacing rule |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_zero | input | 1 | Read pointer clear strobe |
| rd_adv | input | 1 | Read pointer advance qualifier |
| rd_show | input | 1 | Read output enable (low blanks the slot) |
| rd_data | output | DATA_W | Registered output byte, 0 when not valid |
| rd_valid | output | 1 | Output slot carries a fetched byte |
| rd_gap_err | output | 1 | Sticky flag: read clear strobe broke the spacing rule |

## Verification
A 16-entry instance is swept through whole fields. The sweeps mix hold cycles into both the write and read streams, so that a pointer that moves when it should stand still shifts every later byte. A masked pass rewrites only two addresses in three, which shows whether a suppressed store leaves the old byte or whether the pointer also stalls. A pass with the output enable switched off on every other fetch separates skipped slots from held ones. Strobes spaced one edge apart show whether the spacing filter works and whether its flag is sticky. Three overlapped write/read runs, with the reader cleared 0, 1 and 5 read clocks after the writer, show whether the data is old or new. The 0-clock case only yields old data when the write path carries its one-edge lag.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

    // Minimum number of low samples a clear strobe needs before it counts.
    localparam int unsigned GAP_MIN = 2;

    typedef enum logic [1:0] {
        STB_IDLE = 2'd0,
        STB_TAKE = 2'd1,
        STB_DROP = 2'd2
    } stb_kind_e;

endpackage

// File: rtl/fdm_strobe_guard.sv
module fdm_strobe_guard
    import fdm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe_i,
    output stb_kind_e kind_o,
    output logic      err_o
);

    localparam int CW = $clog2(GAP_MIN + 1);

    typedef struct packed {
        logic [CW-1:0] low_cnt;
        logic          err;
    } guard_st_t;

    guard_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        kind_o = STB_IDLE;
        if (strobe_i) begin
            s_d.low_cnt = '0;
            if (s_q.low_cnt >= CW'(GAP_MIN)) begin
                kind_o = STB_TAKE;
            end else if (s_q.low_cnt != '0) begin
                kind_o    = STB_DROP;
                s_d.err   = 1'b1;
            end
        end else if (s_q.low_cnt < CW'(GAP_MIN)) begin
            s_d.low_cnt = s_q.low_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.low_cnt <= CW'(GAP_MIN);
            s_q.err     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign err_o = s_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R7
    AST_TAKE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == STB_TAKE) |=> (kind_o != STB_TAKE)); // R7
    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_o == STB_DROP) |=> err_o); // R7

endmodule

// File: rtl/fdm_wr_port.sv
module fdm_wr_port
    import fdm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stb_kind_e         kind_i,
    input  logic              adv_i,
    input  logic              store_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              we_o,
    output logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // One stage of input capture gives the write side its one-edge lag.
    typedef struct packed {
        logic              stg_clear;
        logic              stg_adv;
        logic              stg_store;
        logic [DATA_W-1:0] stg_data;
        logic [AW-1:0]     ptr;
    } wr_st_t;

    wr_st_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.stg_clear = (kind_i == STB_TAKE);
        s_d.stg_adv   = adv_i && (kind_i != STB_TAKE);
        s_d.stg_store = store_i;
        s_d.stg_data  = data_i;
        if (s_q.stg_clear) begin
            s_d.ptr = '0;
        end else if (s_q.stg_adv) begin
            s_d.ptr = (s_q.ptr == AW'(DEPTH - 1)) ? '0 : s_q.ptr + AW'(1);
        end
        we_o    = s_q.stg_adv && s_q.stg_store;
        waddr_o = s_q.ptr;
        wdata_o = s_q.stg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_WE_LAGS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> $past(adv_i && store_i && (kind_i != STB_TAKE))); // R9
    AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.stg_adv && !s_q.stg_clear) |=> $stable(s_q.ptr)); // R3
    AST_WPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stg_clear |=> (s_q.ptr == '0)); // R2

endmodule

// File: rtl/fdm_rd_port.sv
module fdm_rd_port
    import fdm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stb_kind_e         kind_i,
    input  logic              adv_i,
    input  logic              show_i,
    input  logic [DATA_W-1:0] ram_q_i,
    output logic              re_o,
    output logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] raddr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0]     ptr;
        logic              fetch_v;
        logic              fetch_show;
        logic              out_valid;
        logic [DATA_W-1:0] out_data;
    } rd_st_t;

    rd_st_t s_d, s_q;

    always_comb begin
        s_d            = s_q;
        re_o           = adv_i && (kind_i != STB_TAKE);
        raddr_o        = s_q.ptr;
        s_d.fetch_v    = re_o;
        s_d.fetch_show = show_i;
        if (kind_i == STB_TAKE) begin
            s_d.ptr = '0;
        end else if (adv_i) begin
            s_d.ptr = (s_q.ptr == AW'(DEPTH - 1)) ? '0 : s_q.ptr + AW'(1);
        end
        s_d.out_valid = s_q.fetch_v && s_q.fetch_show;
        s_d.out_data  = (s_q.fetch_v && s_q.fetch_show) ? ram_q_i : '0;
        data_o        = s_q.out_data;
        valid_o       = s_q.out_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && (kind_i != STB_TAKE)) |=> $stable(s_q.ptr)); // R5
    AST_VALID_NEEDS_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.out_valid |-> $past(show_i && adv_i, 2)); // R6
    AST_DARK_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.out_valid |-> (s_q.out_data == '0)); // R6
    AST_RPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == STB_TAKE) |=> (s_q.ptr == '0)); // R2

endmodule

// File: rtl/fdm_dpram.sv
module fdm_dpram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
    import fdm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_zero,
    input  logic              wr_adv,
    input  logic              wr_store,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_gap_err,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_zero,
    input  logic              rd_adv,
    input  logic              rd_show,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_gap_err
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stb_kind_e         w_kind, r_kind;
    logic              w_we, r_re;
    logic [AW-1:0]     w_addr, r_addr;
    logic [DATA_W-1:0] w_wdata, r_ramq;

    fdm_strobe_guard u_wguard (
        .clk(wr_clk), .rst_n(wr_rst_n), .strobe_i(wr_zero),
        .kind_o(w_kind), .err_o(wr_gap_err)
    );

    fdm_strobe_guard u_rguard (
        .clk(rd_clk), .rst_n(rd_rst_n), .strobe_i(rd_zero),
        .kind_o(r_kind), .err_o(rd_gap_err)
    );

    fdm_wr_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_wport (
        .clk(wr_clk), .rst_n(wr_rst_n), .kind_i(w_kind),
        .adv_i(wr_adv), .store_i(wr_store), .data_i(wr_data),
        .we_o(w_we), .waddr_o(w_addr), .wdata_o(w_wdata)
    );

    fdm_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wclk(wr_clk), .we(w_we), .waddr(w_addr), .wdata(w_wdata),
        .rclk(rd_clk), .re(r_re), .raddr(r_addr), .rdata(r_ramq)
    );

    fdm_rd_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rport (
        .clk(rd_clk), .rst_n(rd_rst_n), .kind_i(r_kind),
        .adv_i(rd_adv), .show_i(rd_show), .ram_q_i(r_ramq),
        .re_o(r_re), .raddr_o(r_addr), .data_o(rd_data), .valid_o(rd_valid)
    );

endmodule

// File: tb/sim_field_delay_mem.sv
module sim_field_delay_mem;

    localparam int DW  = 8;
    localparam int DEP = 16;

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n, rd_rst_n;
    logic          wr_zero, wr_adv, wr_store;
    logic [DW-1:0] wr_data;
    logic          wr_gap_err;
    logic          rd_zero, rd_adv, rd_show;
    logic [DW-1:0] rd_data;
    logic          rd_valid, rd_gap_err;

    field_delay_mem #(.DATA_W(DW), .DEPTH(DEP)) u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_zero(wr_zero),
        .wr_adv(wr_adv), .wr_store(wr_store), .wr_data(wr_data),
        .wr_gap_err(wr_gap_err),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_zero(rd_zero),
        .rd_adv(rd_adv), .rd_show(rd_show), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_gap_err(rd_gap_err)
    );

    // 100 MHz on both sides; read edges sit 3 ns after write edges.
    initial forever #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    logic [DW-1:0] mmem [DEP];
    int wptr = 0, rptr = 0, wlow = 2, rlow = 2;
    int cur_field = 0;
    logic          e1v = 1'b0, e2v = 1'b0;
    logic [DW-1:0] e1d = '0, e2d = '0;
    string         e1t = "R1", e2t = "R1";

    function automatic logic [DW-1:0] fld(int f, int a);
        return DW'((f * 37 + a * 5 + 1) & 255);
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wstep(bit z, bit a, bit s, logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_zero = z; wr_adv = a; wr_store = s; wr_data = d;
        @(posedge wr_clk);
        if (z && wlow >= 2) begin
            wptr = 0;
        end else begin
            if (z && wlow == 1) begin
                // spacing violation: ignored, flag expected
            end
            if (a) begin
                if (s) mmem[wptr] = d;
                wptr = (wptr + 1) % DEP;
            end
        end
        wlow = z ? 0 : ((wlow < 2) ? wlow + 1 : 2);
    endtask

    task automatic rstep(bit z, bit a, bit o, bit use_model, logic [DW-1:0] expv, string tag);
        logic [DW-1:0] dd;
        @(negedge rd_clk);
        chk(rd_valid === e2v, e2t, "rd_valid", int'(rd_valid), int'(e2v));
        chk(rd_data === e2d, e2t, "rd_data", int'(rd_data), int'(e2d));
        rd_zero = z; rd_adv = a; rd_show = o;
        @(posedge rd_clk);
        e2v = e1v; e2d = e1d; e2t = e1t;
        if (z && rlow >= 2) begin
            rptr = 0; e1v = 1'b0; e1d = '0;
        end else if (a) begin
            dd  = use_model ? mmem[rptr] : expv;
            e1v = o;
            e1d = o ? dd : '0;
            rptr = (rptr + 1) % DEP;
        end else begin
            e1v = 1'b0; e1d = '0;
        end
        e1t = tag;
        rlow = z ? 0 : ((rlow < 2) ? rlow + 1 : 2);
    endtask

    // Overlapped write of a new field and read, reader cleared d read clocks late.
    task automatic run_field(int f_new, int d, bit want_old, string tag);
        int f_exp;
        f_exp = want_old ? cur_field : f_new;
        wstep(0, 0, 0, '0);
        fork
            begin
                wstep(1, 0, 0, '0);
                for (int i = 0; i < DEP; i++) wstep(0, 1, 1, fld(f_new, i));
                repeat (3) wstep(0, 0, 0, '0);
            end
            begin
                repeat (d) rstep(0, 0, 0, 0, '0, tag);
                rstep(1, 0, 0, 0, '0, tag);
                for (int i = 0; i < DEP; i++) rstep(0, 1, 1, 0, fld(f_exp, i), tag);
                repeat (2) rstep(0, 0, 0, 0, '0, tag);
            end
        join
        cur_field = f_new;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEP; i++) mmem[i] = '0;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        wr_zero = 0; wr_adv = 0; wr_store = 0; wr_data = '0;
        rd_zero = 0; rd_adv = 0; rd_show = 0;
        repeat (3) @(posedge wr_clk);
        @(negedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge rd_clk);
        // R1: reset state at the ports
        chk(rd_valid === 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
        chk(rd_data === '0, "R1", "rd_data", int'(rd_data), 0);
        chk(wr_gap_err === 1'b0, "R1", "wr_gap_err", int'(wr_gap_err), 0);
        chk(rd_gap_err === 1'b0, "R1", "rd_gap_err", int'(rd_gap_err), 0);

        // R1: both pointers start at 0 without any strobe
        wstep(0, 1, 1, 8'hA1); wstep(0, 1, 1, 8'hA2); wstep(0, 1, 1, 8'hA3);
        repeat (2) wstep(0, 0, 0, '0);
        for (int i = 0; i < 3; i++) rstep(0, 1, 1, 1, '0, "R1");
        repeat (2) rstep(0, 0, 0, 1, '0, "R1");

        // R2/R3/R8: clear with adv ignored, holds mixed in, wrap past the end
        wstep(1, 1, 1, 8'hEE);
        for (int i = 0; i < DEP + 3; i++) begin
            wstep(0, 1, 1, fld(1, i));
            if (i % 2 == 1) wstep(0, 0, 1, 8'h55);
        end
        repeat (2) wstep(0, 0, 0, '0);
        rstep(1, 1, 1, 1, '0, "R2");
        for (int i = 0; i < DEP + 3; i++) begin
            rstep(0, 1, 1, 1, '0, (i < DEP) ? "R3" : "R8");
            if (i % 3 == 2) rstep(0, 0, 1, 1, '0, "R5");
        end
        repeat (2) rstep(0, 0, 0, 1, '0, "R5");

        // R4: masked stores keep old bytes, pointer still advances
        wstep(1, 0, 0, '0);
        for (int i = 0; i < DEP; i++) wstep(0, 1, (i % 3) != 0, fld(2, i));
        repeat (2) wstep(0, 0, 0, '0);
        rstep(1, 0, 0, 1, '0, "R4");
        for (int i = 0; i < DEP; i++) rstep(0, 1, 1, 1, '0, "R4");
        repeat (2) rstep(0, 0, 0, 1, '0, "R4");

        // R6: output enable off on every other fetch
        rstep(1, 0, 0, 1, '0, "R6");
        for (int i = 0; i < DEP; i++) rstep(0, 1, (i % 2) == 1, 1, '0, "R6");
        repeat (2) rstep(0, 0, 0, 1, '0, "R6");

        // R7: strobes with a one-edge gap are dropped and flagged
        chk(wr_gap_err === 1'b0, "R7", "wr_gap_err before", int'(wr_gap_err), 0);
        chk(rd_gap_err === 1'b0, "R7", "rd_gap_err before", int'(rd_gap_err), 0);
        wstep(1, 0, 0, '0);
        wstep(0, 1, 1, 8'hC0);
        wstep(1, 0, 0, '0);
        wstep(0, 1, 1, 8'hC1);
        repeat (3) wstep(0, 0, 0, '0);
        rstep(1, 0, 0, 1, '0, "R7");
        rstep(0, 1, 1, 1, '0, "R7");
        rstep(1, 0, 0, 1, '0, "R7");
        rstep(0, 1, 1, 1, '0, "R7");
        repeat (3) rstep(0, 0, 0, 1, '0, "R7");
        chk(wr_gap_err === 1'b1, "R7", "wr_gap_err after", int'(wr_gap_err), 1);
        chk(rd_gap_err === 1'b1, "R7", "rd_gap_err after", int'(rd_gap_err), 1);
        wstep(1, 0, 0, '0);
        repeat (2) wstep(0, 0, 0, '0);
        rstep(1, 0, 0, 1, '0, "R7");
        repeat (2) rstep(0, 0, 0, 1, '0, "R7");
        chk(wr_gap_err === 1'b1, "R7", "wr_gap_err sticky", int'(wr_gap_err), 1);
        chk(rd_gap_err === 1'b1, "R7", "rd_gap_err sticky", int'(rd_gap_err), 1);

        // R9/R10: prefill a field, then overlapped runs
        wstep(1, 0, 0, '0);
        for (int i = 0; i < DEP; i++) wstep(0, 1, 1, fld(1, i));
        repeat (3) wstep(0, 0, 0, '0);
        cur_field = 1;
        run_field(2, 0, 1'b1, "R9");   // reader 3 ns behind the strobe: old field
        run_field(3, 1, 1'b0, "R10");  // one clock behind: new field
        run_field(4, 5, 1'b0, "R10");  // well behind: new field

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule